// File: doc/BRIEF.md
# Atomic Sequence Snoop Monitor

This block guards a multi-line atomic sequence run by a core. Each locked load arms a monitor entry for the 64-byte cache line it reads. While the sequence is still gathering lines, any coherence snoop that hits an armed line marks the sequence as disturbed. At a point the core chooses, it issues an interference query. A clean answer lets the core go on to commit. A disturbed answer tells it to abandon every update and take its failure path. In that case the monitors and the flag are dropped at once.

After a clean query the block protects the participating lines. Snoops that hit them are refused with a NaK, so the requester backs off instead of taking the line away mid-update. A requester inside its own atomic sequence treats the NaK as a failure. Any other requester simply reissues its request. The locked store that closes the sequence releases all monitors, and snoops are then acknowledged normally again. An abort command drops everything in any state.

Commands use `cmd_op_i` with the encoding 0 = locked load, 1 = interference query, 2 = locked store, 3 = abort. `state_o` uses the encoding 0 = idle, 1 = arming, 2 = committing, 3 = release. A line is identified by address bits [31:6].

Top module: `atom_seq_monitor`

## Requirements
- R1: A locked load (op 0) accepted in idle or arming arms an entry for line address bits [31:6] and moves to arming (state 1). A second load to a line that is already armed uses no new entry. Any address inside that 64-byte line then counts as a hit.
- R2: While arming, a snoop whose line matches an armed entry sets `intf_o` on the next cycle, and the snoop is acknowledged.
- R3: A query (op 0b01) accepted in arming raises `rsp_valid_o` on the next cycle. `rsp_ok_o` is 1 when no interference was recorded, and the state becomes committing (2).
- R4: A failed query returns to idle with every entry and `intf_o` cleared on the next cycle, so later snoops to those lines do not hit.
- R5: In committing, a snoop to an armed line receives `snp_nak_o` in the same cycle.
- R6: A locked store (op 2) in committing releases all entries. The state is release (3) for one cycle, then idle, and snoops to the former lines are acknowledged.
- R7: A snoop to a line that is not armed is always acknowledged and never changes `intf_o`.
- R8: With 8 distinct lines armed, a locked load to a ninth distinct line sets `intf_o`, and the following query fails.
- R9: An abort (op 3) in any state gives idle, no armed entries and `intf_o` low on the next cycle.
- R10: When a matching snoop and a query arrive in the same arming cycle, the query reports failure.
- R11: Loads outside idle or arming, queries outside arming and stores outside committing are ignored: state, flag and entries stay unchanged and no response is raised.
- R12: Every valid snoop gets exactly one of `snp_ack_o` or `snp_nak_o` in the same cycle. With no snoop, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Core command valid |
| cmd_op_i | input | 2 | 0 load, 1 query, 2 store, 3 abort |
| cmd_addr_i | input | 32 | Byte address of a load or store |
| snp_valid_i | input | 1 | Incoming snoop valid |
| snp_addr_i | input | 32 | Snoop byte address |
| snp_ack_o | output | 1 | Snoop accepted |
| snp_nak_o | output | 1 | Snoop refused |
| rsp_valid_o | output | 1 | Query result valid (one cycle after the query) |
| rsp_ok_o | output | 1 | Query result: 1 means no interference |
| intf_o | output | 1 | Interference recorded for the current sequence |
| state_o | output | 2 | Sequence state |

## Verification
The collision that matters here is a snoop hitting an armed line in the very cycle the core asks for its interference verdict. A second collision is a locked load and a matching snoop arriving together. The bench drives both pairs in the same cycle, at directed points and in a long random run over a small pool of lines. A per-cycle behavioural model then judges them: the query must report failure and the state must fall to idle with the flag clear. The same model checks that a snoop arriving together with the closing store is still refused.

// File: rtl/atom_mon_pkg.sv
`timescale 1ns/1ps
package atom_mon_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_QUERY = 2'd1,
    OP_STORE = 2'd2,
    OP_ABORT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMING  = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_RELEASE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/atom_mon_entries.sv
`timescale 1ns/1ps
module atom_mon_entries #(
  parameter int N_ENT = 8,
  parameter int TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             ld_hit_o,
  output logic             snp_hit_o,
  output logic             full_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [N_ENT];
  logic [N_ENT-1:0] ld_m, snp_m;
  logic [IDX_W-1:0] free_idx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign ld_m[g]  = vld_q[g] && (tag_q[g] == ld_tag_i);
    assign snp_m[g] = vld_q[g] && (tag_q[g] == snp_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (alloc_i && (free_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= ld_tag_i;
      end
    end
  end

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign ld_hit_o  = |ld_m;
  assign snp_hit_o = |snp_m;
  assign full_o    = &vld_q;
endmodule

// File: rtl/atom_mon_seq.sv
`timescale 1ns/1ps
module atom_mon_seq
  import atom_mon_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_valid_i,
  input  op_e     cmd_op_i,
  input  logic    snp_valid_i,
  input  logic    snp_hit_i,
  input  logic    ld_hit_i,
  input  logic    full_i,
  output seq_st_e state_o,
  output logic    ent_clr_o,
  output logic    ent_alloc_o,
  output logic    nak_o,
  output logic    intf_o,
  output logic    rsp_valid_o,
  output logic    rsp_ok_o
);
  seq_st_e st_q, st_d;
  logic intf_q, intf_d;
  logic rv_q, ok_q;
  logic is_load, is_query, is_store, is_abort;
  logic ld_acc, q_acc, q_ok, q_fail, sto_acc, open_st, flag_set;

  always_comb begin
    is_load  = cmd_valid_i && (cmd_op_i == OP_LOAD);
    is_query = cmd_valid_i && (cmd_op_i == OP_QUERY);
    is_store = cmd_valid_i && (cmd_op_i == OP_STORE);
    is_abort = cmd_valid_i && (cmd_op_i == OP_ABORT);
    open_st  = (st_q == ST_IDLE) || (st_q == ST_ARMING);
    ld_acc   = is_load && open_st;
    q_acc    = is_query && (st_q == ST_ARMING);
    // snoop in the query cycle beats the query
    q_ok     = !intf_q && !(snp_valid_i && snp_hit_i);
    q_fail   = q_acc && !q_ok;
    sto_acc  = is_store && (st_q == ST_COMMIT);

    ent_alloc_o = ld_acc && !ld_hit_i && !full_i;
    ent_clr_o   = is_abort || q_fail || sto_acc;
    flag_set    = open_st && ((snp_valid_i && snp_hit_i) ||
                              (ld_acc && !ld_hit_i && full_i));

    if (is_abort || q_fail) intf_d = 1'b0;
    else if (flag_set)      intf_d = 1'b1;
    else                    intf_d = intf_q;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_ARMING: begin
        if (ld_acc) st_d = ST_ARMING;
        if (q_acc)  st_d = q_ok ? ST_COMMIT : ST_IDLE;
      end
      ST_COMMIT:  if (sto_acc) st_d = ST_RELEASE;
      ST_RELEASE: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (is_abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      intf_q <= 1'b0;
      rv_q   <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      intf_q <= intf_d;
      rv_q   <= q_acc;
      ok_q   <= q_acc && q_ok;
    end
  end

  assign nak_o       = snp_valid_i && snp_hit_i && (st_q == ST_COMMIT);
  assign state_o     = st_q;
  assign intf_o      = intf_q;
  assign rsp_valid_o = rv_q;
  assign rsp_ok_o    = ok_q;
endmodule

// File: rtl/atom_seq_monitor.sv
`timescale 1ns/1ps
module atom_seq_monitor
  import atom_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int N_ENT    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_ack_o,
  output logic              snp_nak_o,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              intf_o,
  output logic [1:0]        state_o
);
  localparam int TAG_W = ADDR_W - LINE_OFF;

  logic [TAG_W-1:0] ld_tag, snp_tag;
  logic ld_hit, snp_hit, full, ent_clr, ent_alloc, nak;
  seq_st_e st;
  logic unused_low;

  assign ld_tag     = cmd_addr_i[ADDR_W-1:LINE_OFF];
  assign snp_tag    = snp_addr_i[ADDR_W-1:LINE_OFF];
  assign unused_low = ^{cmd_addr_i[LINE_OFF-1:0], snp_addr_i[LINE_OFF-1:0]};

  atom_mon_entries #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_entries (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ent_clr),
    .alloc_i   (ent_alloc),
    .ld_tag_i  (ld_tag),
    .snp_tag_i (snp_tag),
    .ld_hit_o  (ld_hit),
    .snp_hit_o (snp_hit),
    .full_o    (full)
  );

  atom_mon_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (op_e'(cmd_op_i)),
    .snp_valid_i (snp_valid_i),
    .snp_hit_i   (snp_hit),
    .ld_hit_i    (ld_hit),
    .full_i      (full),
    .state_o     (st),
    .ent_clr_o   (ent_clr),
    .ent_alloc_o (ent_alloc),
    .nak_o       (nak),
    .intf_o      (intf_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ok_o    (rsp_ok_o)
  );

  assign state_o   = st;
  assign snp_nak_o = nak;
  assign snp_ack_o = snp_valid_i && !nak;
endmodule

// File: rtl/atom_mon_chk.sv
`timescale 1ns/1ps
module atom_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_op_i,
  input logic       snp_valid_i,
  input logic       snp_hit,
  input logic       snp_ack_o,
  input logic       snp_nak_o,
  input logic       rsp_valid_o,
  input logic       rsp_ok_o,
  input logic       intf_o,
  input logic [1:0] state_o
);
  p_one_resp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> (snp_ack_o ^ snp_nak_o));
  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> (!snp_ack_o && !snp_nak_o));
  p_nak_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_nak_o |-> (state_o == 2'd2));
  p_hit_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && snp_valid_i && snp_hit &&
     !(cmd_valid_i && (cmd_op_i == 2'd1 || cmd_op_i == 2'd3))) |=> intf_o);
  p_miss_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && snp_valid_i && !snp_hit && !cmd_valid_i) |=> (intf_o == $past(intf_o)));
  p_ok_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ok_o) |-> (state_o == 2'd2));
  p_fail_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ok_o) |-> (state_o == 2'd0 && !intf_o));
  p_same_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && cmd_valid_i && cmd_op_i == 2'd1 && snp_valid_i && snp_hit)
      |=> (rsp_valid_o && !rsp_ok_o));
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3) |=> (state_o == 2'd0 && !intf_o));
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |=> (state_o == 2'd0));
endmodule

bind atom_seq_monitor atom_mon_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .snp_valid_i (snp_valid_i),
  .snp_hit     (snp_hit),
  .snp_ack_o   (snp_ack_o),
  .snp_nak_o   (snp_nak_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o),
  .intf_o      (intf_o),
  .state_o     (state_o)
);

// File: tb/atom_seq_monitor_tb.sv
`timescale 1ns/1ps
module atom_seq_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [31:0] cmd_addr = '0;
  logic snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic snp_ack, snp_nak, rsp_valid, rsp_ok, intf;
  logic [1:0] state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [25:0] mq[$];
  int m_st = 0;
  bit m_flag = 1'b0;
  bit m_rv = 1'b0;
  bit m_ok = 1'b0;

  always #2.5 clk = ~clk;

  atom_seq_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .snp_valid_i(snp_valid), .snp_addr_i(snp_addr),
    .snp_ack_o(snp_ack), .snp_nak_o(snp_nak),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok),
    .intf_o(intf), .state_o(state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_q(input logic [25:0] t);
    foreach (mq[i]) if (mq[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit cv, input int op, input logic [31:0] ca,
                      input bit sv, input logic [31:0] sa, input string req);
    bit hit, ldhit, set_f, exp_nak;
    int st0;
    @(negedge clk);
    cmd_valid = cv; cmd_op = 2'(op); cmd_addr = ca;
    snp_valid = sv; snp_addr = sa;
    #1;
    hit     = sv && in_q(sa[31:6]);
    exp_nak = hit && (m_st == 2);
    chk(req, "snp_nak", int'(snp_nak), int'(exp_nak));
    chk(req, "snp_ack", int'(snp_ack), int'(sv && !exp_nak));
    // model update with pre-edge values
    st0 = m_st;
    ldhit = in_q(ca[31:6]);
    set_f = (st0 <= 1) && hit;
    m_rv = 1'b0; m_ok = 1'b0;
    if (st0 == 3) m_st = 0;
    if (cv) begin
      case (op)
        0: if (st0 <= 1) begin
             m_st = 1;
             if (!ldhit) begin
               if (mq.size() < 8) mq.push_back(ca[31:6]);
               else set_f = 1'b1;
             end
           end
        1: if (st0 == 1) begin
             m_rv = 1'b1;
             m_ok = !m_flag && !hit;
             if (m_ok) m_st = 2;
             else begin m_st = 0; mq.delete(); m_flag = 1'b0; set_f = 1'b0; end
           end
        2: if (st0 == 2) begin m_st = 3; mq.delete(); end
        default: begin m_st = 0; mq.delete(); m_flag = 1'b0; set_f = 1'b0; end
      endcase
    end
    if (set_f) m_flag = 1'b1;
    @(posedge clk);
    #1;
    chk(req, "state", int'(state), m_st);
    chk(req, "intf", int'(intf), int'(m_flag));
    chk(req, "rsp_valid", int'(rsp_valid), int'(m_rv));
    chk(req, "rsp_ok", int'(rsp_ok), int'(m_ok));
  endtask

  task automatic idle_cyc(input string req);
    step(0, 0, 0, 0, 0, req);
  endtask

  localparam logic [31:0] LA = 32'h0000_1000;
  localparam logic [31:0] LB = 32'h0000_2040;
  localparam logic [31:0] LC = 32'h0000_3080;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset state", int'(state), 0);
    chk("R9", "reset intf", int'(intf), 0);
    chk("R12", "reset ack", int'(snp_ack), 0);
    rst_n = 1'b1;

    // clean sequence: load, duplicate, miss snoop, query ok, nak, store
    step(1, 0, LA, 0, 0, "R1");
    step(1, 0, LB, 0, 0, "R1");
    step(1, 0, LA + 32'h10, 0, 0, "R1");
    step(0, 0, 0, 1, LC, "R7");
    step(1, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 1, LA + 32'h3F, "R5");
    step(0, 0, 0, 1, LC, "R7");
    step(1, 0, LC, 0, 0, "R11");
    step(1, 1, 0, 0, 0, "R11");
    step(1, 2, LB, 1, LB, "R6");
    step(0, 0, 0, 1, LB, "R6");
    step(0, 0, 0, 1, LA, "R6");

    // interference then failed query
    step(1, 2, LA, 0, 0, "R11");
    step(1, 1, 0, 0, 0, "R11");
    step(1, 0, LA, 0, 0, "R1");
    step(0, 0, 0, 1, LA + 32'h20, "R2");
    step(1, 2, LA, 0, 0, "R11");
    step(1, 1, 0, 0, 0, "R4");
    step(1, 0, LB, 0, 0, "R4");
    step(0, 0, 0, 1, LA, "R4");
    step(1, 3, 0, 0, 0, "R9");

    // snoop and query in the same cycle; load and snoop together
    step(1, 0, LA, 0, 0, "R10");
    step(1, 1, 0, 1, LA, "R10");
    step(1, 0, LB, 1, LB, "R10");
    step(1, 0, LA, 1, LB, "R2");
    step(1, 3, 0, 0, 0, "R9");

    // capacity overflow
    for (int i = 0; i < 8; i++) step(1, 0, 32'h0001_0000 + 32'(i) * 64, 0, 0, "R8");
    step(1, 0, 32'h0001_0000, 0, 0, "R8");
    step(1, 0, 32'h0002_0000, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");

    // abort in arming and in committing
    step(1, 0, LC, 0, 0, "R9");
    step(1, 3, 0, 1, LC, "R9");
    step(0, 0, 0, 1, LC, "R9");
    step(1, 0, LC, 0, 0, "R9");
    step(1, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 1, LC, "R5");
    step(1, 3, 0, 0, 0, "R9");
    step(0, 0, 0, 1, LC, "R9");
    idle_cyc("R12");

    // random run over a small line pool
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [31:0] ca, sa;
      r  = $urandom_range(0, 99);
      ca = 32'h0000_4000 + 32'($urandom_range(0, 9)) * 64 + 32'($urandom_range(0, 63));
      sa = 32'h0000_4000 + 32'($urandom_range(0, 11)) * 64 + 32'($urandom_range(0, 63));
      step(r < 70, (r < 40) ? 0 : (r < 55) ? 1 : (r < 67) ? 2 : 3, ca,
           $urandom_range(0, 2) == 0, sa, "R12");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule